// File: doc/BRIEF.md
# Four-Bank Asynchronous Static Memory Controller

This controller takes one request at a time from an internal port and runs it as a read or write cycle on an external asynchronous bus. The bus is shared by four banks of static memory or FIFO parts. Each bank has its own settings: an enable, a ready-honour flag, a select-shaping mode, and four cycle counts. The counts set the setup, access and hold phase lengths and the number of bus-idle turnaround cycles. All outputs toward the bus are active-low strobes and selects, plus an address, write data and a data-drive enable.

The state machine has five states: `ST_IDLE`, `ST_TURN`, `ST_SETUP`, `ST_ACCESS` and `ST_HOLD`.

- `ST_IDLE` takes a request whenever `req_valid` is high. It then moves as follows:
  - If the bank is disabled, it stays in `ST_IDLE` and pulses done.
  - If the request changes bank or direction relative to the last enabled access, and that bank's turnaround count is non-zero, it goes to `ST_TURN`.
  - Otherwise it goes to `ST_SETUP`.
- `ST_TURN` goes to `ST_SETUP` when its count runs out.
- `ST_SETUP` goes to `ST_ACCESS` when its count runs out.
- `ST_ACCESS` goes to `ST_HOLD` when its count is used up and, if the bank honours ready, `mem_ready` is high. While ready stays low, `ST_ACCESS` simply repeats, with no limit.
- `ST_HOLD` goes back to `ST_IDLE` when its count runs out, and pulses done.

For FIFO parts that have no chip select, a bank's select output can be gated with the read strobe or the write strobe. The select pin can then drive the part's output or write enable directly.

Top module: `amc_ctrl`

## Requirements
- R1: For an enabled bank in plain select mode (mode code 0 or 3), that bank's select is low for max(S,1)+max(A,1)+max(H,1) consecutive cycles, using that bank's own setup S, access A and hold H counts. No other bank's select goes low, and the read or write strobe is low for max(A,1) of those cycles.
- R2: A request to a disabled bank drives no select, strobe or data enable. Done pulses in the cycle after acceptance with read data 0. The request does not count as the previous access for turnaround decisions.
- R3: Before an access whose bank or direction differs from the previous enabled access, exactly T cycles with no select, strobe or data enable are inserted, where T is the new bank's turnaround count. When neither bank nor direction changes, no idle cycle is inserted.
- R4: When the bank honours ready, the strobe stays low while `mem_ready` is low after the minimum access count, for any number of cycles. The access ends in the first cycle that `mem_ready` is high.
- R5: When a bank's ready-honour flag is 0, `mem_ready` has no effect and the strobe lasts exactly max(A,1) cycles.
- R6: After a ready-extended access phase, the hold phase still lasts its full max(H,1) cycles.
- R7: In select mode 1 (read-gated), the bank select is low only in cycles where the read strobe is low.
- R8: In select mode 2 (write-gated), the bank select is low only in cycles where the write strobe is low, so it never goes low on a read.
- R9: `mem_dq_oe` is high only for writes, for every cycle of setup, access and hold, and never during turnaround or on reads. Address and write data are stable on the bus while the write strobe is low.
- R10: `req_ready` is high only when idle. Done is a single-cycle pulse in the cycle after the hold phase ends. Read data equals the bus value sampled in the last access cycle, and is 0 for writes.
- R11: After reset all selects and strobes are high, `mem_dq_oe` is low, `req_ready` is high and `rsp_done` is low.
- R12: A programmed setup, access or hold count of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_bank | input | BW | Target bank index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read data (0 for writes and disabled banks) |
| cfg_en | input | NBANK | Per-bank enable |
| cfg_rdy_en | input | NBANK | Per-bank ready-honour flag |
| cfg_sel | input | 2*NBANK | Per-bank select mode: 0/3 plain, 1 read-gated, 2 write-gated |
| cfg_setup | input | CW*NBANK | Per-bank setup cycle count |
| cfg_access | input | CW*NBANK | Per-bank minimum access cycle count |
| cfg_hold | input | CW*NBANK | Per-bank hold cycle count |
| cfg_turn | input | CW*NBANK | Per-bank turnaround idle count |
| mem_cs_n | output | NBANK | Active-low bank selects |
| mem_re_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_addr | output | AW | Bus address |
| mem_dq_out | output | DW | Bus write data |
| mem_dq_oe | output | 1 | Bus data drive enable |
| mem_dq_in | input | DW | Bus read data |
| mem_ready | input | 1 | Device ready, low means wait |

## Verification
The requests run in sequence so that the previous access sets up each turnaround case:
- A repeat read to the same bank tells "no change" apart from a direction flip on the same bank. A same-direction move to another bank isolates the bank-change condition.
- A request to a disabled bank sits between two reads of one bank. This shows whether the ignored request disturbed the bank-change history.
- Ready is held low for a short and for a long stretch on a bank that honours it, and held low on a bank that ignores it. This separates extension from a fixed access length.
- Reads and writes on read-gated and write-gated banks show whether the select follows the matching strobe, the other strobe, or the whole access.

// File: rtl/amc_pkg.sv
package amc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_SETUP,
        ST_ACCESS,
        ST_HOLD
    } amc_state_e;

    typedef enum logic [1:0] {
        SEL_PLAIN     = 2'd0,
        SEL_RD_GATED  = 2'd1,
        SEL_WR_GATED  = 2'd2,
        SEL_PLAIN_ALT = 2'd3
    } amc_sel_e;

endpackage

// File: rtl/amc_cfg_pick.sv
// Selects one bank's settings out of the flattened per-bank vectors.
module amc_cfg_pick #(
    parameter int NBANK = 4,
    parameter int CW    = 4,
    parameter int BW    = 2
) (
    input  logic [BW-1:0]       bank_idx,
    input  logic [NBANK-1:0]    en_vec,
    input  logic [NBANK-1:0]    rdy_vec,
    input  logic [2*NBANK-1:0]  sel_vec,
    input  logic [CW*NBANK-1:0] setup_vec,
    input  logic [CW*NBANK-1:0] access_vec,
    input  logic [CW*NBANK-1:0] hold_vec,
    input  logic [CW*NBANK-1:0] turn_vec,
    output logic                en,
    output logic                rdy_en,
    output logic [1:0]          sel,
    output logic [CW-1:0]       setup,
    output logic [CW-1:0]       access,
    output logic [CW-1:0]       hold,
    output logic [CW-1:0]       turn
);

    always_comb begin
        en     = en_vec[bank_idx];
        rdy_en = rdy_vec[bank_idx];
        sel    = sel_vec[bank_idx*2 +: 2];
        setup  = setup_vec[bank_idx*CW +: CW];
        access = access_vec[bank_idx*CW +: CW];
        hold   = hold_vec[bank_idx*CW +: CW];
        turn   = turn_vec[bank_idx*CW +: CW];
    end

endmodule

// File: rtl/amc_phase_cnt.sv
// Phase length counter; a load of 0 or 1 both give a one-cycle phase.
module amc_phase_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q > CW'(1)) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign last = (cnt_q <= CW'(1));

endmodule

// File: rtl/amc_sel_gen.sv
// Per-bank active-low select shaping: plain, read-gated or write-gated.
module amc_sel_gen
    import amc_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int BW    = 2
) (
    input  logic [BW-1:0]      active_bank,
    input  logic               cs_act,
    input  logic               re_act,
    input  logic               we_act,
    input  logic [2*NBANK-1:0] sel_vec,
    output logic [NBANK-1:0]   cs_n
);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic hit;
        logic low;
        amc_sel_e mode;

        always_comb begin
            mode = amc_sel_e'(sel_vec[2*g +: 2]);
            hit  = cs_act && (active_bank == BW'(g));
            unique case (mode)
                SEL_RD_GATED: low = hit && re_act;
                SEL_WR_GATED: low = hit && we_act;
                default:      low = hit;
            endcase
            cs_n[g] = ~low;
        end
    end

endmodule

// File: rtl/amc_ctrl.sv
module amc_ctrl
    import amc_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int CW    = 4,
    localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [BW-1:0]       req_bank,
    input  logic                req_write,
    input  logic [AW-1:0]       req_addr,
    input  logic [DW-1:0]       req_wdata,
    output logic                rsp_done,
    output logic [DW-1:0]       rsp_rdata,
    input  logic [NBANK-1:0]    cfg_en,
    input  logic [NBANK-1:0]    cfg_rdy_en,
    input  logic [2*NBANK-1:0]  cfg_sel,
    input  logic [CW*NBANK-1:0] cfg_setup,
    input  logic [CW*NBANK-1:0] cfg_access,
    input  logic [CW*NBANK-1:0] cfg_hold,
    input  logic [CW*NBANK-1:0] cfg_turn,
    output logic [NBANK-1:0]    mem_cs_n,
    output logic                mem_re_n,
    output logic                mem_we_n,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_dq_out,
    output logic                mem_dq_oe,
    input  logic [DW-1:0]       mem_dq_in,
    input  logic                mem_ready
);

    amc_state_e state_q, state_d;

    logic [BW-1:0] cur_bank;
    logic          cur_write;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_wdata;
    logic [DW-1:0] rdata_q;
    logic          done_q;
    logic          has_prev;
    logic [BW-1:0] last_bank;
    logic          last_write;

    logic [BW-1:0] pick_idx;
    logic          c_en, c_rdy_en;
    logic [1:0]    c_sel;
    logic [CW-1:0] c_setup, c_access, c_hold, c_turn;

    logic          cnt_load;
    logic [CW-1:0] cnt_val;
    logic          cnt_last;
    logic          accept;
    logic          need_turn;
    logic          leave_access;
    logic          cs_act, re_act, we_act;

    // In idle the incoming request's bank decides; otherwise the active one.
    assign pick_idx = (state_q == ST_IDLE) ? req_bank : cur_bank;

    amc_cfg_pick #(.NBANK(NBANK), .CW(CW), .BW(BW)) u_pick (
        .bank_idx  (pick_idx),
        .en_vec    (cfg_en),
        .rdy_vec   (cfg_rdy_en),
        .sel_vec   (cfg_sel),
        .setup_vec (cfg_setup),
        .access_vec(cfg_access),
        .hold_vec  (cfg_hold),
        .turn_vec  (cfg_turn),
        .en        (c_en),
        .rdy_en    (c_rdy_en),
        .sel       (c_sel),
        .setup     (c_setup),
        .access    (c_access),
        .hold      (c_hold),
        .turn      (c_turn)
    );

    amc_phase_cnt #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_val),
        .last    (cnt_last)
    );

    assign need_turn = has_prev && (c_turn != '0) &&
                       ((req_bank != last_bank) || (req_write != last_write));

    // Next-state and phase-counter load decisions.
    always_comb begin
        state_d      = state_q;
        cnt_load     = 1'b0;
        cnt_val      = '0;
        accept       = 1'b0;
        leave_access = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (!c_en) begin
                        state_d = ST_IDLE;
                    end else if (need_turn) begin
                        state_d  = ST_TURN;
                        cnt_load = 1'b1;
                        cnt_val  = c_turn;
                    end else begin
                        state_d  = ST_SETUP;
                        cnt_load = 1'b1;
                        cnt_val  = c_setup;
                    end
                end
            end
            ST_TURN: begin
                if (cnt_last) begin
                    state_d  = ST_SETUP;
                    cnt_load = 1'b1;
                    cnt_val  = c_setup;
                end
            end
            ST_SETUP: begin
                if (cnt_last) begin
                    state_d  = ST_ACCESS;
                    cnt_load = 1'b1;
                    cnt_val  = c_access;
                end
            end
            ST_ACCESS: begin
                if (cnt_last && (!c_rdy_en || mem_ready)) begin
                    leave_access = 1'b1;
                    state_d      = ST_HOLD;
                    cnt_load     = 1'b1;
                    cnt_val      = c_hold;
                end
            end
            ST_HOLD: begin
                if (cnt_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture, direction/bank history and response.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_bank   <= '0;
            cur_write  <= 1'b0;
            cur_addr   <= '0;
            cur_wdata  <= '0;
            rdata_q    <= '0;
            done_q     <= 1'b0;
            has_prev   <= 1'b0;
            last_bank  <= '0;
            last_write <= 1'b0;
        end else begin
            done_q <= (state_q == ST_HOLD && cnt_last) || (accept && !c_en);
            if (accept) begin
                cur_bank  <= req_bank;
                cur_write <= req_write;
                cur_addr  <= req_addr;
                cur_wdata <= req_wdata;
                rdata_q   <= '0;
                if (c_en) begin
                    has_prev   <= 1'b1;
                    last_bank  <= req_bank;
                    last_write <= req_write;
                end
            end else if (leave_access && !cur_write) begin
                rdata_q <= mem_dq_in;
            end
        end
    end

    // Output decode from the state register.
    always_comb begin
        cs_act     = (state_q == ST_SETUP) || (state_q == ST_ACCESS) ||
                     (state_q == ST_HOLD);
        re_act     = (state_q == ST_ACCESS) && !cur_write;
        we_act     = (state_q == ST_ACCESS) && cur_write;
        mem_re_n   = ~re_act;
        mem_we_n   = ~we_act;
        mem_dq_oe  = cs_act && cur_write;
        mem_addr   = cur_addr;
        mem_dq_out = cur_wdata;
        req_ready  = (state_q == ST_IDLE);
        rsp_done   = done_q;
        rsp_rdata  = rdata_q;
    end

    amc_sel_gen #(.NBANK(NBANK), .BW(BW)) u_sel (
        .active_bank(cur_bank),
        .cs_act     (cs_act),
        .re_act     (re_act),
        .we_act     (we_act),
        .sel_vec    (cfg_sel),
        .cs_n       (mem_cs_n)
    );

endmodule

// File: rtl/amc_chk.sv
module amc_chk #(
    parameter int NBANK = 4,
    parameter int BW    = 2,
    parameter int AW    = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_ready,
    input logic               rsp_done,
    input logic [NBANK-1:0]   mem_cs_n,
    input logic               mem_re_n,
    input logic               mem_we_n,
    input logic               mem_dq_oe,
    input logic               mem_ready,
    input logic [AW-1:0]      mem_addr,
    input logic               cnt_last,
    input logic               rdy_on,
    input logic [BW-1:0]      cur_bank,
    input logic [2*NBANK-1:0] sel_vec
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&mem_cs_n && mem_re_n && mem_we_n && !mem_dq_oe)); // R2

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_cs_n) <= 1); // R1

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_re_n && !mem_we_n)); // R9

    AST_OE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_re_n); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R10

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_re_n && $past(!mem_re_n)) |-> $stable(mem_addr)); // R9

    AST_WAIT_EXTENDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((!mem_re_n || !mem_we_n) && cnt_last && rdy_on && !mem_ready)
        |=> (!mem_re_n || !mem_we_n)); // R4

    AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_vec[cur_bank*2 +: 2] == 2'd1 && !mem_cs_n[cur_bank]) |-> !mem_re_n); // R7

    AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_vec[cur_bank*2 +: 2] == 2'd2 && !mem_cs_n[cur_bank]) |-> !mem_we_n); // R8

endmodule

bind amc_ctrl amc_chk #(.NBANK(NBANK), .BW(BW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .rsp_done (rsp_done),
    .mem_cs_n (mem_cs_n),
    .mem_re_n (mem_re_n),
    .mem_we_n (mem_we_n),
    .mem_dq_oe(mem_dq_oe),
    .mem_ready(mem_ready),
    .mem_addr (mem_addr),
    .cnt_last (cnt_last),
    .rdy_on   (c_rdy_en),
    .cur_bank (cur_bank),
    .sel_vec  (cfg_sel)
);

// File: tb/sim_amc_ctrl.sv
`timescale 1ns/1ps
module sim_amc_ctrl;

    localparam int NBANK = 4;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 4;
    localparam int BW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic                req_valid = 1'b0;
    logic                req_ready;
    logic [BW-1:0]       req_bank = '0;
    logic                req_write = 1'b0;
    logic [AW-1:0]       req_addr = '0;
    logic [DW-1:0]       req_wdata = '0;
    logic                rsp_done;
    logic [DW-1:0]       rsp_rdata;
    logic [NBANK-1:0]    cfg_en = '0;
    logic [NBANK-1:0]    cfg_rdy_en = '0;
    logic [2*NBANK-1:0]  cfg_sel = '0;
    logic [CW*NBANK-1:0] cfg_setup = '0;
    logic [CW*NBANK-1:0] cfg_access = '0;
    logic [CW*NBANK-1:0] cfg_hold = '0;
    logic [CW*NBANK-1:0] cfg_turn = '0;
    logic [NBANK-1:0]    mem_cs_n;
    logic                mem_re_n, mem_we_n, mem_dq_oe;
    logic [AW-1:0]       mem_addr;
    logic [DW-1:0]       mem_dq_out;
    logic [DW-1:0]       mem_dq_in;
    logic                mem_ready = 1'b1;

    amc_ctrl #(.NBANK(NBANK), .AW(AW), .DW(DW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .cfg_en(cfg_en), .cfg_rdy_en(cfg_rdy_en), .cfg_sel(cfg_sel),
        .cfg_setup(cfg_setup), .cfg_access(cfg_access), .cfg_hold(cfg_hold),
        .cfg_turn(cfg_turn),
        .mem_cs_n(mem_cs_n), .mem_re_n(mem_re_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_ready(mem_ready)
    );

    // Device model: read data derived from the address.
    assign mem_dq_in = mem_addr ^ 16'hA5A5;

    // Ready goes high once the strobe has been low for ready_after samples.
    int act_n = 0;
    int ready_after = 0;
    always @(negedge clk) begin
        if (!mem_re_n || !mem_we_n) act_n = act_n + 1;
        else act_n = 0;
        mem_ready = (act_n >= ready_after);
    end

    int n_cmp = 0;
    int n_bad = 0;

    // Per-access observations.
    int o_total, o_lead, o_cs, o_other, o_re, o_we, o_oe, o_oe_lead;
    int o_mis_rd, o_mis_wr, o_busbad, o_rdy_hi, o_done2;
    logic [DW-1:0] o_rdata;

    task automatic chk(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic set_bank(input int b, input bit en, input bit rdy, input int sel,
                            input int s, input int a, input int h, input int t);
        cfg_en[b] = en;
        cfg_rdy_en[b] = rdy;
        cfg_sel[b*2 +: 2] = 2'(sel);
        cfg_setup[b*CW +: CW] = CW'(s);
        cfg_access[b*CW +: CW] = CW'(a);
        cfg_hold[b*CW +: CW] = CW'(h);
        cfg_turn[b*CW +: CW] = CW'(t);
    endtask

    task automatic run_acc(input int b, input bit w, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input int rdy_after);
        bit seen;
        bit act;
        @(negedge clk);
        ready_after = rdy_after;
        req_valid = 1'b1;
        req_bank = 2'(b);
        req_write = w;
        req_addr = a;
        req_wdata = d;
        @(posedge clk);
        #1 req_valid = 1'b0;
        o_total = 0; o_lead = 0; o_cs = 0; o_other = 0; o_re = 0; o_we = 0;
        o_oe = 0; o_oe_lead = 0; o_mis_rd = 0; o_mis_wr = 0; o_busbad = 0;
        o_rdy_hi = 0; o_rdata = '0; seen = 1'b0;
        for (int k = 0; k < 500; k++) begin
            @(negedge clk);
            if (rsp_done) begin
                o_rdata = rsp_rdata;
                break;
            end
            o_total++;
            act = (~mem_cs_n != '0) || !mem_re_n || !mem_we_n || mem_dq_oe;
            if (act) seen = 1'b1;
            if (!seen) o_lead++;
            if (!seen && mem_dq_oe) o_oe_lead++;
            if (!mem_cs_n[b]) o_cs++;
            for (int j = 0; j < NBANK; j++)
                if (j != b && !mem_cs_n[j]) o_other++;
            if (!mem_re_n) o_re++;
            if (!mem_we_n) o_we++;
            if (mem_dq_oe) o_oe++;
            if ((!mem_cs_n[b]) != (!mem_re_n)) o_mis_rd++;
            if ((!mem_cs_n[b]) != (!mem_we_n)) o_mis_wr++;
            if (!mem_we_n && (mem_addr != a || mem_dq_out != d)) o_busbad++;
            if (req_ready) o_rdy_hi++;
        end
        @(negedge clk);
        o_done2 = rsp_done;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11 selects high", int'(mem_cs_n), 15);
        chk("R11 read strobe high", int'(mem_re_n), 1);
        chk("R11 write strobe high", int'(mem_we_n), 1);
        chk("R11 drive off", int'(mem_dq_oe), 0);
        chk("R11 req_ready", int'(req_ready), 1);
        chk("R11 done low", int'(rsp_done), 0);
    endtask

    task automatic t_plain_read();
        set_bank(0, 1, 0, 0, 2, 3, 1, 2);
        run_acc(0, 0, 16'h0010, 16'h0, 0);
        chk("R3 first access no idle", o_lead, 0);
        chk("R1 select length", o_cs, 6);
        chk("R1 other selects", o_other, 0);
        chk("R1 read strobe length", o_re, 3);
        chk("R9 no drive on read", o_oe, 0);
        chk("R10 read data", int'(o_rdata), 'hA5B5);
        chk("R10 ready low while busy", o_rdy_hi, 0);
        chk("R10 done single pulse", o_done2, 0);
        run_acc(0, 0, 16'h0022, 16'h0, 0);
        chk("R3 same bank same dir no idle", o_lead, 0);
        chk("R10 second read data", int'(o_rdata), 'hA587);
    endtask

    task automatic t_dir_change();
        run_acc(0, 1, 16'h0030, 16'h1234, 0);
        chk("R3 direction change idle", o_lead, 2);
        chk("R9 drive off in turnaround", o_oe_lead, 0);
        chk("R9 drive setup..hold", o_oe, 6);
        chk("R1 write strobe length", o_we, 3);
        chk("R9 bus stable under strobe", o_busbad, 0);
        chk("R10 write returns zero", int'(o_rdata), 0);
    endtask

    task automatic t_bank_change_zero();
        set_bank(1, 1, 0, 0, 0, 0, 0, 3);
        run_acc(1, 1, 16'h0040, 16'hBEEF, 0);
        chk("R3 bank change idle", o_lead, 3);
        chk("R12 zero counts as one", o_cs, 3);
        chk("R12 zero access", o_we, 1);
    endtask

    task automatic t_ready_wait();
        set_bank(2, 1, 1, 0, 1, 2, 2, 1);
        run_acc(2, 0, 16'h0050, 16'h0, 7);
        chk("R3 bank+dir change idle", o_lead, 1);
        chk("R4 strobe extended", o_re, 7);
        chk("R6 hold after wait", o_cs, 10);
        chk("R10 read data after wait", int'(o_rdata), 'hA5F5);
        run_acc(2, 0, 16'h0051, 16'h0, 42);
        chk("R4 long wait", o_re, 42);
        chk("R6 long wait select", o_cs, 45);
    endtask

    task automatic t_ready_ignored();
        set_bank(3, 1, 0, 0, 1, 2, 1, 0);
        run_acc(3, 0, 16'h0060, 16'h0, 50);
        chk("R5 ready ignored strobe", o_re, 2);
        chk("R5 ready ignored select", o_cs, 4);
    endtask

    task automatic t_disabled();
        set_bank(1, 0, 0, 0, 2, 2, 2, 3);
        run_acc(1, 1, 16'h0070, 16'h5555, 0);
        chk("R2 done next cycle", o_total, 0);
        chk("R2 no select", o_cs + o_other, 0);
        chk("R2 no write strobe", o_we, 0);
        chk("R2 no drive", o_oe, 0);
        chk("R2 read data zero", int'(o_rdata), 0);
        set_bank(3, 1, 0, 0, 1, 2, 1, 2);
        run_acc(3, 0, 16'h0061, 16'h0, 0);
        chk("R2 history untouched", o_lead, 0);
        chk("R1 bank3 select", o_cs, 4);
    endtask

    task automatic t_merge();
        set_bank(2, 1, 0, 1, 2, 3, 2, 0);
        run_acc(2, 0, 16'h0080, 16'h0, 0);
        chk("R7 gated select length", o_cs, 3);
        chk("R7 select follows read strobe", o_mis_rd, 0);
        chk("R7 read data", int'(o_rdata), 'hA525);
        set_bank(2, 1, 0, 2, 2, 3, 2, 0);
        run_acc(2, 1, 16'h0081, 16'hC0DE, 0);
        chk("R8 gated select length", o_cs, 3);
        chk("R8 select follows write strobe", o_mis_wr, 0);
        chk("R9 drive full write", o_oe, 7);
        run_acc(2, 0, 16'h0082, 16'h0, 0);
        chk("R8 no select on read", o_cs, 0);
        chk("R8 read still strobed", o_re, 3);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R10 watchdog: got hung expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_plain_read();
        t_dir_change();
        t_bank_change_zero();
        t_ready_wait();
        t_ready_ignored();
        t_disabled();
        t_merge();
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule